// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

This block is one 32-pin general-purpose I/O bank controlled through a simple single-cycle memory-mapped read/write port. Software sets each pin's output value and output enable and reads back the pin levels through a two-flop synchronizer. The same port configures per-pin interrupt detection. Each pin has four configuration bits: a routing bit that lets the pin record events, an enable bit that lets recorded events reach an interrupt line, and two trigger bits that choose level or edge sensing and its polarity.

Detected events are latched into a sticky status register. The main interrupt line is high whenever any pin has both its status bit and its enable bit set. When the upper-half line is configured, pins 16 to 31 drive it instead of the main line. Every writable register has three addresses: a plain write, a set alias that ORs the written ones into the register, and a clear alias that clears the written ones. Drivers can therefore change single bits without a read-modify-write sequence.

Top module: `gpio_bank_irq`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `pad_oe` is zero, and both interrupt lines are low.
- R2: Address bits [6:4] select the register: 0 output data, 1 input data, 2 output enable, 3 interrupt routing, 4 interrupt enable, 5 trigger level-select, 6 trigger polarity, 7 status. Bits [3:2] select the access kind: 0 plain write, 1 set, 2 clear, 3 ignored. A read at any alias returns the register value. An address with bit 7 set reads zero and ignores writes.
- R3: A set-alias write ORs `bus_wdata` into the register. A clear-alias write clears the bits where `bus_wdata` is 1. All other bits are unchanged.
- R4: `pad_oe` equals the output-enable register. `pad_out` carries the output-data bit where output enable is 1, and is 0 elsewhere.
- R5: The input-data register shows `pad_in` after two synchronizing flops, whatever the output enable is. Writes to the input-data register have no effect.
- R6: Each pin's trigger code is {polarity, level-select}: 0 is a falling edge, 1 is a low level, 2 is a rising edge, 3 is a high level. An edge is found by comparing the synchronized level with its value one cycle earlier.
- R7: A status bit is set only for a pin whose routing bit is 1. The interrupt-enable bit does not affect latching. It only masks whether the status bit reaches an interrupt line.
- R8: Status bits are sticky. Only a clear-alias write to the status register clears them. Plain and set writes to the status register are ignored.
- R9: When a pin's event and a clear of its status bit happen in the same cycle, the bit stays set. A pin held at its active level sets its status bit again on every cycle.
- R10: With the upper line configured, `irq_main` is the OR of (status AND enable) over pins 0 to 15, and `irq_upper` is the same OR over pins 16 to 31. Both lines are combinational from those registers.
- R11: A pad change made before clock edge k appears in the status register after edge k+2, which is the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address (register group and alias) |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| pad_in | input | 32 | Pin levels from the pads, asynchronous |
| pad_out | output | 32 | Output data to the pads, gated by output enable |
| pad_oe | output | 32 | Per-pin output enable |
| irq_main | output | 1 | Bank interrupt (pins 0 to 15 when the upper line exists) |
| irq_upper | output | 1 | Upper-half interrupt for pins 16 to 31 |

## Verification
The assertions check four properties on every cycle: no pin carries output data without its output enable, a status bit never rises for a pin that was not routed, a status bit never drops except under a clear-alias write that names it, and an interrupt line is never high while the status register is empty. The bench scenarios cover the rest. These are the exact trigger meaning of each of the four codes, the three-edge latency from pad to status, a held level winning over a clear, the split between the two interrupt lines, and the handling of ignored and unmapped accesses, seen through read-back.

// File: rtl/gpio_bank_pkg.sv
// Shared types for the GPIO bank: the register group codes, the access alias
// codes and the decoded bus command. The group and alias encodings fix the
// address map, so the software view depends on them.
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        GRP_DOUT  = 3'd0,
        GRP_DIN   = 3'd1,
        GRP_OE    = 3'd2,
        GRP_ROUTE = 3'd3,
        GRP_EN    = 3'd4,
        GRP_LEVEL = 3'd5,
        GRP_POL   = 3'd6,
        GRP_STAT  = 3'd7
    } grp_e;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLEAR = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef struct packed {
        logic wr_valid;
        logic rd_valid;
        grp_e grp;
        acc_e acc;
    } bus_cmd_t;

endpackage

// File: rtl/gpio_bus_decode.sv
// Splits a bus access into its register group and alias kind.
// Assumes ADDR_W >= 8. Any address with a bit at position 7 or above set is
// unmapped: it never reads or writes a register.
module gpio_bus_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_cmd_t          cmd_o
);

    localparam int GRP_LSB = 4;
    localparam int ACC_LSB = 2;

    logic mapped;

    // Purpose: an address is mapped only when every bit above the group field is zero.
    always_comb begin
        mapped = ((bus_addr >> (GRP_LSB + 3)) == '0);
        cmd_o.wr_valid = bus_sel && bus_wr && mapped;
        cmd_o.rd_valid = bus_sel && !bus_wr && mapped;
        cmd_o.grp      = grp_e'(bus_addr[GRP_LSB +: 3]);
        cmd_o.acc      = acc_e'(bus_addr[ACC_LSB +: 2]);
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
// Holds the software-written registers (output data, output enable, routing,
// enable, level-select, polarity). Each one accepts plain, set and clear
// writes. The input-data and status slots of the output array are tied to
// zero, because other blocks own them.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  bus_cmd_t              cmd_i,
    input  logic [NPINS-1:0]      wdata_i,
    output logic [7:0][NPINS-1:0] cfg_o
);

    localparam int NGRP = 8;

    // Purpose: computes a register's next value from the alias kind.
    function automatic logic [NPINS-1:0] apply_acc(
        input logic [NPINS-1:0] old_v,
        input logic [NPINS-1:0] wr_v,
        input acc_e             acc
    );
        case (acc)
            ACC_WRITE: apply_acc = wr_v;
            ACC_SET:   apply_acc = old_v | wr_v;
            ACC_CLEAR: apply_acc = old_v & ~wr_v;
            default:   apply_acc = old_v;
        endcase
    endfunction

    for (genvar g = 0; g < NGRP; g++) begin : g_reg
        if (g == int'(GRP_DIN) || g == int'(GRP_STAT)) begin : g_none
            assign cfg_o[g] = '0;
        end else begin : g_store
            logic [NPINS-1:0] q;
            // Purpose: updates this register on a write addressed to its group.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (cmd_i.wr_valid && cmd_i.grp == grp_e'(g))
                    q <= apply_acc(q, wdata_i, cmd_i.acc);
            end
            assign cfg_o[g] = q;
        end
    end

endmodule

// File: rtl/gpio_sync.sv
// Multi-flop synchronizer for the pad inputs. Assumes STAGES >= 2.
// The last stage is the synchronized level used for read-back and sensing.
module gpio_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] async_i,
    output logic [NPINS-1:0] sync_o
);

    logic [STAGES-1:0][NPINS-1:0] stage_q;

    // Purpose: shifts the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else
            stage_q <= {stage_q[STAGES-2:0], async_i};
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_sense.sv
// Per-pin event detection and the sticky status register.
// Assumes pin_s_i is already synchronous. The trigger code is
// {pol, level}: 0 falling, 1 low, 2 rising, 3 high. A hardware set wins
// over a software clear in the same cycle.
module gpio_irq_sense #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_s_i,
    input  logic [NPINS-1:0] route_i,
    input  logic [NPINS-1:0] level_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic             clr_en_i,
    input  logic [NPINS-1:0] clr_mask_i,
    output logic [NPINS-1:0] status_o
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] clr_bits;

    // Purpose: keeps the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= pin_s_i;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic active_lvl;
        logic active_edge;
        assign active_lvl  = pol_i[p] ? pin_s_i[p] : ~pin_s_i[p];
        assign active_edge = pol_i[p] ? (pin_s_i[p] & ~prev_q[p])
                                      : (~pin_s_i[p] & prev_q[p]);
        assign hit[p] = route_i[p] & (level_i[p] ? active_lvl : active_edge);
    end

    assign clr_bits = clr_en_i ? clr_mask_i : '0;

    // Purpose: sticky status; clear first, then OR in new events so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_bits) | hit;
    end

    assign status_o = status_q;

endmodule

// File: rtl/gpio_bank_irq.sv
// Top of the GPIO bank: decodes the bus, holds configuration, synchronizes
// the pads, senses events and drives the interrupt lines.
// Assumes NPINS is even when UPPER_IRQ is 1. Reads are combinational in the
// access cycle.
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int ADDR_W    = 8,
    parameter int SYNC_STG  = 2,
    parameter bit UPPER_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_main,
    output logic              irq_upper
);

    localparam int HALF = NPINS / 2;

    bus_cmd_t               cmd;
    logic [7:0][NPINS-1:0]  cfg;
    logic [NPINS-1:0]       pin_s;
    logic [NPINS-1:0]       status_q;
    logic [NPINS-1:0]       route_q;
    logic [NPINS-1:0]       en_q;
    logic [NPINS-1:0]       pend;
    logic                   stat_clr;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .cmd_o    (cmd)
    );

    gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd),
        .wdata_i (bus_wdata),
        .cfg_o   (cfg)
    );

    gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pin_s)
    );

    assign route_q  = cfg[GRP_ROUTE];
    assign en_q     = cfg[GRP_EN];
    assign stat_clr = cmd.wr_valid && cmd.grp == GRP_STAT && cmd.acc == ACC_CLEAR;

    gpio_irq_sense #(.NPINS(NPINS)) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s_i    (pin_s),
        .route_i    (route_q),
        .level_i    (cfg[GRP_LEVEL]),
        .pol_i      (cfg[GRP_POL]),
        .clr_en_i   (stat_clr),
        .clr_mask_i (bus_wdata),
        .status_o   (status_q)
    );

    // Purpose: selects the read-back source for the addressed group.
    always_comb begin
        bus_rdata = '0;
        if (cmd.rd_valid) begin
            case (cmd.grp)
                GRP_DIN:  bus_rdata = pin_s;
                GRP_STAT: bus_rdata = status_q;
                default:  bus_rdata = cfg[cmd.grp];
            endcase
        end
    end

    assign pad_oe  = cfg[GRP_OE];
    assign pad_out = cfg[GRP_DOUT] & cfg[GRP_OE];
    assign pend    = status_q & en_q;

    if (UPPER_IRQ) begin : g_split
        assign irq_main  = |pend[HALF-1:0];
        assign irq_upper = |pend[NPINS-1:HALF];
    end else begin : g_single
        assign irq_main  = |pend;
        assign irq_upper = 1'b0;
    end

endmodule

// File: rtl/gpio_bank_checker.sv
// Cycle-by-cycle properties of the GPIO bank, attached by bind.
// Assumes the top has internal signals status_q and route_q.
module gpio_bank_checker #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic              irq_main,
    input logic              irq_upper,
    input logic [NPINS-1:0]  status_q,
    input logic [NPINS-1:0]  route_q
);

    logic             clr_wr;
    logic [NPINS-1:0] clr_mask;

    assign clr_wr   = bus_sel && bus_wr && ((bus_addr >> 7) == '0)
                      && bus_addr[6:4] == 3'd7 && bus_addr[3:2] == 2'd2;
    assign clr_mask = clr_wr ? bus_wdata : '0;

    assert_out_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    assert_route_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(route_q)) == '0));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_mask)) == '0));

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_main || irq_upper) |-> ($countones(status_q) != 0));

endmodule

bind gpio_bank_irq gpio_bank_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_main  (irq_main),
    .irq_upper (irq_upper),
    .status_q  (status_q),
    .route_q   (route_q)
);

// File: tb/test_gpio_bank_irq.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks queue the expected observations, and a
// monitor pops and compares each one when the driver signals it.
module test_gpio_bank_irq;

    localparam int G_DOUT = 0, G_DIN = 1, G_OE = 2, G_ROUTE = 3;
    localparam int G_EN = 4, G_LEVEL = 5, G_POL = 6, G_STAT = 7;
    localparam int A_WR = 0, A_SET = 1, A_CLR = 2, A_NONE = 3;
    localparam int K_RDATA = 0, K_POUT = 1, K_POE = 2, K_IRQM = 3, K_IRQU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_main;
    logic        irq_upper;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank_irq i_gpio_bank_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_main  (irq_main),
        .irq_upper (irq_upper)
    );

    function automatic logic [7:0] adr(input int g, input int a);
        return 8'(g * 16 + a * 4);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic set_pads(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Driver: sets up an observation and queues what it should show.
    task automatic expect_obs(input int kind, input logic [7:0] a,
                              input logic [31:0] exp, input string req);
        item_t it;
        @(negedge clk);
        if (kind == K_RDATA) begin
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        end
        #1;
        it.kind = kind; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
        bus_sel = 1'b0;
    endtask

    // Monitor: pops one expected item per trigger and compares it.
    initial begin
        forever begin
            item_t       it;
            logic [31:0] act;
            @(sample_ev);
            it = sb_q.pop_front();
            case (it.kind)
                K_RDATA: act = bus_rdata;
                K_POUT:  act = pad_out;
                K_POE:   act = pad_oe;
                K_IRQM:  act = {31'd0, irq_main};
                default: act = {31'd0, irq_upper};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_obs(K_RDATA, adr(G_DOUT, A_WR), 32'h0, "R1 dout");
        expect_obs(K_RDATA, adr(G_OE, A_WR), 32'h0, "R1 oe");
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R1 status");
        expect_obs(K_POE, 8'h0, 32'h0, "R1 pad_oe");
        expect_obs(K_IRQM, 8'h0, 32'h0, "R1 irq_main");
        expect_obs(K_IRQU, 8'h0, 32'h0, "R1 irq_upper");

        // R3: plain, set and clear aliases
        wr(adr(G_DOUT, A_WR), 32'hA5A5_5A5A);
        expect_obs(K_RDATA, adr(G_DOUT, A_WR), 32'hA5A5_5A5A, "R3 plain");
        wr(adr(G_DOUT, A_SET), 32'h0000_00F0);
        expect_obs(K_RDATA, adr(G_DOUT, A_WR), 32'hA5A5_5AFA, "R3 set");
        wr(adr(G_DOUT, A_CLR), 32'hA500_0000);
        expect_obs(K_RDATA, adr(G_DOUT, A_WR), 32'h00A5_5AFA, "R3 clear");
        // R2: reads at aliases, ignored alias, unmapped address
        expect_obs(K_RDATA, adr(G_DOUT, A_SET), 32'h00A5_5AFA, "R2 read set alias");
        expect_obs(K_RDATA, adr(G_DOUT, A_CLR), 32'h00A5_5AFA, "R2 read clear alias");
        wr(adr(G_DOUT, A_NONE), 32'h0);
        expect_obs(K_RDATA, adr(G_DOUT, A_WR), 32'h00A5_5AFA, "R2 alias 3 ignored");
        wr(8'h80, 32'h0);
        expect_obs(K_RDATA, adr(G_DOUT, A_WR), 32'h00A5_5AFA, "R2 unmapped write ignored");
        expect_obs(K_RDATA, 8'h80, 32'h0, "R2 unmapped read");

        // R4: output gating
        wr(adr(G_OE, A_WR), 32'h0000_FFFF);
        expect_obs(K_POE, 8'h0, 32'h0000_FFFF, "R4 pad_oe");
        expect_obs(K_POUT, 8'h0, 32'h0000_5AFA, "R4 pad_out");

        // R5: input read-back, independent of oe; writes ignored
        set_pads(32'h1234_5678);
        settle();
        expect_obs(K_RDATA, adr(G_DIN, A_WR), 32'h1234_5678, "R5 din");
        wr(adr(G_DIN, A_WR), 32'hFFFF_FFFF);
        expect_obs(K_RDATA, adr(G_DIN, A_WR), 32'h1234_5678, "R5 din write ignored");
        set_pads(32'h0);
        wr(adr(G_OE, A_WR), 32'h0);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R7 no route no status");

        // R6: pin 3, high level (code 3)
        wr(adr(G_LEVEL, A_SET), 32'h8);
        wr(adr(G_POL, A_SET), 32'h8);
        wr(adr(G_ROUTE, A_SET), 32'h8);
        wr(adr(G_EN, A_SET), 32'h8);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R6 high level inactive");
        set_pads(32'h8);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h8, "R6 high level");
        expect_obs(K_IRQM, 8'h0, 32'h1, "R10 irq_main lower pin");
        expect_obs(K_IRQU, 8'h0, 32'h0, "R10 irq_upper quiet");
        // R9: clear while level still active
        wr(adr(G_STAT, A_CLR), 32'h8);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h8, "R9 set wins over clear");
        set_pads(32'h0);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h8, "R8 sticky after level gone");
        wr(adr(G_STAT, A_WR), 32'h0);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h8, "R8 plain write ignored");
        wr(adr(G_STAT, A_SET), 32'hFFFF_0000);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h8, "R8 set write ignored");
        wr(adr(G_STAT, A_CLR), 32'h8);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R8 clear alias");
        expect_obs(K_IRQM, 8'h0, 32'h0, "R10 irq_main drops");

        // R11 and R6: pin 20, rising edge (code 2)
        wr(adr(G_POL, A_SET), 32'h0010_0000);
        wr(adr(G_ROUTE, A_SET), 32'h0010_0000);
        wr(adr(G_EN, A_SET), 32'h0010_0000);
        set_pads(32'h0010_0000);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R11 after edge 1");
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R11 after edge 2");
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0010_0000, "R11 after edge 3");
        expect_obs(K_IRQU, 8'h0, 32'h1, "R10 irq_upper upper pin");
        expect_obs(K_IRQM, 8'h0, 32'h0, "R10 irq_main not from upper pin");
        set_pads(32'h0);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0010_0000, "R8 edge sticky");
        wr(adr(G_STAT, A_CLR), 32'h0010_0000);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R6 rising ignores fall");

        // R6: pin 5, falling edge (code 0)
        wr(adr(G_ROUTE, A_SET), 32'h20);
        wr(adr(G_EN, A_SET), 32'h20);
        set_pads(32'h20);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R6 falling ignores rise");
        set_pads(32'h0);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h20, "R6 falling edge");
        wr(adr(G_STAT, A_CLR), 32'h20);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R8 falling cleared");

        // R7 and R6: pin 6, low level (code 1), enable masks only
        wr(adr(G_LEVEL, A_SET), 32'h40);
        wr(adr(G_ROUTE, A_SET), 32'h40);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h40, "R6 low level");
        expect_obs(K_IRQM, 8'h0, 32'h0, "R7 masked by enable");
        wr(adr(G_EN, A_SET), 32'h40);
        expect_obs(K_IRQM, 8'h0, 32'h1, "R7 unmasked");
        wr(adr(G_EN, A_CLR), 32'h40);
        expect_obs(K_IRQM, 8'h0, 32'h0, "R7 masked again");
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h40, "R7 status kept while masked");
        set_pads(32'h40);
        settle();
        wr(adr(G_STAT, A_CLR), 32'h40);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R6 low level released");

        // R7: pin 9 enabled but not routed
        wr(adr(G_LEVEL, A_SET), 32'h200);
        wr(adr(G_POL, A_SET), 32'h200);
        wr(adr(G_EN, A_SET), 32'h200);
        set_pads(32'h240);
        settle();
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h0, "R7 unrouted no status");
        expect_obs(K_IRQM, 8'h0, 32'h0, "R7 unrouted no irq");
        wr(adr(G_ROUTE, A_SET), 32'h200);
        expect_obs(K_RDATA, adr(G_STAT, A_WR), 32'h200, "R7 routed latches");
        expect_obs(K_IRQM, 8'h0, 32'h1, "R10 routed irq");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule